// File: doc/BRIEF.md
# Infrared carrier modulator

This block produces the square-wave carrier that drives an infrared emitter. Software programs two registers through a simple write port. The control register holds a global enable, a hold-high flag used during configuration, and a selector that picks which of four tick references paces the carrier counters. The modulation register holds the lengths of the carrier's high and low phases, counted in selected ticks.

While the block is enabled and the symbol sequencer holds the modulation input high, the output toggles between a high phase and a low phase of the programmed lengths. When modulation is off, the output rests at the idle low level and the phase counter returns to the start of a high phase. While the block is disabled, the output shows the hold-high flag, so the emitter line can be parked high during configuration.

A new modulation word written during a burst is applied only at the next period boundary, so no phase is ever cut short or stretched. A one-cycle strobe marks every period boundary and gives the sequencer a carrier-rate timebase.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset the output and the strobe are low, the control register is cleared (disabled, hold-high off, source code 0), and the modulation word is zero, which gives one tick per phase.
- R2: A write with address 0 loads the control register: enable at bit 0, hold-high at bit 2, tick source at bits 13:12. A write with address 1 loads the modulation word.
- R3: The tick source codes are 0 for every system clock cycle, 1 for the crystal/3 tick input, 2 for the 1 us tick input and 3 for the 10 us tick input. The phase counter advances only on the selected tick.
- R4: Bits 31:16 of the modulation word hold the high-phase length minus one and bits 15:0 hold the low-phase length minus one. A carrier period is therefore (high+1)+(low+1) ticks.
- R5: While disabled, the output is high when the hold-high bit is set and low when it is clear.
- R6: While enabled with the modulation input low, the output is low and no strobe is emitted.
- R7: When modulation starts, the output goes high on the next clock and shows a complete high phase first.
- R8: A modulation write made during a burst takes effect at the next period boundary. The period in progress completes with the old lengths. A write made while not modulating takes effect before the next burst starts.
- R9: The strobe is high for exactly one cycle per period, in the last cycle of the low phase.
- R10: While enabled, the hold-high bit has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 modulation |
| wr_data | input | 32 | Register write data |
| tick_xtal3 | input | 1 | Crystal/3 tick enable, one cycle wide |
| tick_1us | input | 1 | 1 us tick enable, one cycle wide |
| tick_10us | input | 1 | 10 us tick enable, one cycle wide |
| mod_en | input | 1 | Modulation request from the symbol sequencer |
| carrier_out | output | 1 | Registered carrier to the emitter driver |
| period_strobe | output | 1 | One-cycle pulse at each carrier period boundary |

## Verification
Four properties are checked on every cycle: the idle-low and hold-high output levels, the counter staying within the active phase limit, the active modulation word staying frozen between period boundaries, and the strobe never lasting two cycles or appearing outside a burst. Only the bench scenarios can show the exact phase lengths in cycles for each tick source, the full first high phase after a restart, and the old-then-new phase lengths across a mid-burst rewrite. Those are measured as run lengths of the output and compared with lengths computed from the programmed counts and the tick spacing.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INIT_BIT = 2;
  localparam int CTRL_SEL_LSB  = 12;
  localparam int SEL_W         = 2;
  localparam int NUM_SRC       = 1 << SEL_W;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_MOD  = 1'b1;

  typedef enum logic [SEL_W-1:0] {
    SRC_SYS   = 2'd0,
    SRC_XTAL3 = 2'd1,
    SRC_1US   = 2'd2,
    SRC_10US  = 2'd3
  } tick_src_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             init_high;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/ir_mod_regs.sv
module ir_mod_regs
  import ir_mod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              running,
  input  logic              period_end,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  hi_lim,
  output logic [CNT_W-1:0]  lo_lim
);
  localparam int MOD_W = 2 * CNT_W;

  logic [MOD_W-1:0] pend_q;
  logic [MOD_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL) begin
        ctrl.enable    <= wr_data[CTRL_EN_BIT];
        ctrl.init_high <= wr_data[CTRL_INIT_BIT];
        ctrl.sel       <= wr_data[CTRL_SEL_LSB +: SEL_W];
      end
      if (wr_en && wr_addr == ADDR_MOD) begin
        pend_q <= wr_data[MOD_W-1:0];
      end
      // the active word only moves at a boundary or while idle
      if (!running || period_end) begin
        act_q <= pend_q;
      end
    end
  end

  assign hi_lim = act_q[MOD_W-1:CNT_W];
  assign lo_lim = act_q[CNT_W-1:0];

  // R8: no change to the active word in the middle of a period
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (running && !period_end) |=> ($stable(hi_lim) && $stable(lo_lim)));
endmodule

// File: rtl/ir_tick_sel.sv
module ir_tick_sel
  import ir_mod_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] src_ticks,
  input  logic [SW-1:0]   sel,
  output logic            tick
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src_ticks[i] && (sel == SW'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/ir_phase_gen.sv
module ir_phase_gen
  import ir_mod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_lim,
  input  logic [CNT_W-1:0] lo_lim,
  input  logic             idle_level,
  output logic             carrier_out,
  output logic             period_strobe,
  output logic             period_end
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_lim;
  logic             at_lim;

  assign cur_lim    = (ph_q == PH_HIGH) ? hi_lim : lo_lim;
  assign at_lim     = (cnt_q == cur_lim);
  assign period_end = running && tick && (ph_q == PH_LOW) && at_lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q          <= PH_HIGH;
      cnt_q         <= '0;
      carrier_out   <= 1'b0;
      period_strobe <= 1'b0;
    end else begin
      if (!running) begin
        ph_q  <= PH_HIGH;
        cnt_q <= '0;
      end else if (tick) begin
        if (at_lim) begin
          cnt_q <= '0;
          ph_q  <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      carrier_out   <= running ? (ph_q == PH_HIGH) : idle_level;
      period_strobe <= period_end;
    end
  end

  // R4: the counter never passes the limit of the phase it is in
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cur_lim);

  // R9: the strobe lasts one cycle and only follows an active burst
  p_strobe_gap_r9: assert property (@(posedge clk) disable iff (rst)
    period_strobe |=> !period_strobe);
  p_strobe_run_r9: assert property (@(posedge clk) disable iff (rst)
    period_strobe |-> $past(running));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
  import ir_mod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_xtal3,
  input  logic              tick_1us,
  input  logic              tick_10us,
  input  logic              mod_en,
  output logic              carrier_out,
  output logic              period_strobe
);
  ctrl_t               ctrl;
  logic [CNT_W-1:0]    hi_lim;
  logic [CNT_W-1:0]    lo_lim;
  logic                running;
  logic                period_end;
  logic                tick;
  logic                idle_level;
  logic [NUM_SRC-1:0]  src_ticks;

  assign running    = ctrl.enable && mod_en;
  assign idle_level = !ctrl.enable && ctrl.init_high;
  // index follows the source codes: system, crystal/3, 1 us, 10 us
  assign src_ticks  = {tick_10us, tick_1us, tick_xtal3, 1'b1};

  ir_mod_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .running    (running),
    .period_end (period_end),
    .ctrl       (ctrl),
    .hi_lim     (hi_lim),
    .lo_lim     (lo_lim)
  );

  ir_tick_sel #(.NSRC(NUM_SRC)) u_tick (
    .src_ticks (src_ticks),
    .sel       (ctrl.sel),
    .tick      (tick)
  );

  ir_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk           (clk),
    .rst           (rst),
    .running       (running),
    .tick          (tick),
    .hi_lim        (hi_lim),
    .lo_lim        (lo_lim),
    .idle_level    (idle_level),
    .carrier_out   (carrier_out),
    .period_strobe (period_strobe),
    .period_end    (period_end)
  );

  // R6 and R10: enabled without modulation rests low
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.enable && !mod_en) |=> !carrier_out);
  // R5: disabled with hold-high parks the line high
  p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.enable && ctrl.init_high) |=> carrier_out);
  // R7: a burst always opens with the high phase
  p_burst_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |=> carrier_out);
endmodule

// File: tb/sim_ir_carrier_mod.sv
module sim_ir_carrier_mod;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick_xtal3 = 1'b0, tick_1us = 1'b0, tick_10us = 1'b0;
  logic        mod_en = 1'b0;
  logic        carrier_out, period_strobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ir_carrier_mod u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_xtal3(tick_xtal3), .tick_1us(tick_1us), .tick_10us(tick_10us),
    .mod_en(mod_en), .carrier_out(carrier_out), .period_strobe(period_strobe)
  );

  // tick references at fixed spacings of 3, 5 and 7 cycles
  always @(negedge clk) begin
    cyc = cyc + 1;
    tick_xtal3 = (cyc % 3 == 0);
    tick_1us   = (cyc % 5 == 0);
    tick_10us  = (cyc % 7 == 0);
  end

  function automatic int src_div(input int src);
    case (src)
      0: return 1;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(input int src, input bit init, input bit en);
    return (32'(src) << 12) | (32'(init) << 2) | 32'(en);
  endfunction

  function automatic logic [31:0] mod_word(input int h, input int l);
    return (32'(h - 1) << 16) | 32'(l - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic addr, input logic [31:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int src, input int h, input int l);
    write_reg(1'b0, ctrl_word(src, 1'b1, 1'b0));
    write_reg(1'b1, mod_word(h, l));
    write_reg(1'b0, ctrl_word(src, 1'b0, 1'b1));
  endtask

  // measure one full period starting at a rising edge of the output
  task automatic meas(output int hi, output int lo, output int st, output int ls);
    logic p;
    p = 1'b1;
    while (1) begin
      @(negedge clk);
      if (p == 1'b0 && carrier_out == 1'b1) break;
      p = carrier_out;
    end
    hi = 0; st = 0; ls = 0;
    while (carrier_out == 1'b1) begin
      hi++; st += int'(period_strobe); @(negedge clk);
    end
    lo = 0;
    while (carrier_out == 1'b0) begin
      lo++; st += int'(period_strobe); ls = int'(period_strobe); @(negedge clk);
    end
  endtask

  task automatic run_check(input int src, input int h, input int l);
    int hi, lo, st, ls, d;
    d = src_div(src);
    meas(hi, lo, st, ls);
    meas(hi, lo, st, ls);
    check(hi == h * d, "R3/R4 high length", hi, h * d);
    check(lo == l * d, "R3/R4 low length", lo, l * d);
    check(st == 1, "R9 strobes per period", st, 1);
    check(ls == 1, "R9 strobe in last low cycle", ls, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, st, ls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(carrier_out == 1'b0, "R1 output in reset", int'(carrier_out), 0);
    check(period_strobe == 1'b0, "R1 strobe in reset", int'(period_strobe), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero word gives one tick per phase
    mod_en = 1'b1;
    write_reg(1'b0, ctrl_word(0, 1'b0, 1'b1));
    run_check(0, 1, 1);

    // R2/R5: hold-high while disabled
    mod_en = 1'b0;
    write_reg(1'b0, ctrl_word(0, 1'b1, 1'b0));
    @(negedge clk);
    check(carrier_out == 1'b1, "R5 hold high", int'(carrier_out), 1);
    write_reg(1'b0, ctrl_word(0, 1'b0, 1'b0));
    @(negedge clk);
    check(carrier_out == 1'b0, "R5 disabled low", int'(carrier_out), 0);
    // R10/R6: enabled with hold-high set and no modulation stays low
    write_reg(1'b0, ctrl_word(0, 1'b1, 1'b1));
    st = 0; lo = 0;
    repeat (6) begin
      @(negedge clk);
      st += int'(period_strobe); lo += int'(carrier_out);
    end
    check(lo == 0, "R10 hold-high ignored when enabled", lo, 0);
    check(st == 0, "R6 no strobe while idle", st, 0);

    // R3/R4/R9: directed corners
    cfg(1, 1, 9); mod_en = 1'b1; run_check(1, 1, 9);
    mod_en = 1'b0;
    cfg(3, 2, 1); mod_en = 1'b1; run_check(3, 2, 1);
    mod_en = 1'b0;

    // constrained random over sources and lengths
    for (int i = 0; i < 10; i++) begin
      int src, h, l;
      src = int'($urandom % 4);
      h = 1 + int'($urandom % 6);
      l = 1 + int'($urandom % 6);
      cfg(src, h, l);
      mod_en = 1'b1;
      run_check(src, h, l);
      mod_en = 1'b0;
    end

    // R6/R7: stop mid high phase, then restart with a full high phase
    cfg(0, 4, 3);
    mod_en = 1'b1;
    meas(hi, lo, st, ls);
    @(negedge clk);
    mod_en = 1'b0;
    st = 0; lo = 0;
    repeat (3) begin
      @(negedge clk);
      st += int'(period_strobe); lo += int'(carrier_out);
    end
    check(lo == 0, "R6 idle low after stop", lo, 0);
    check(st == 0, "R6 no strobe after stop", st, 0);
    mod_en = 1'b1;
    @(negedge clk);
    check(carrier_out == 1'b1, "R7 high on next clock", int'(carrier_out), 1);
    hi = 0;
    while (carrier_out == 1'b1) begin hi++; @(negedge clk); end
    check(hi == 4, "R7 full first high phase", hi, 4);

    // R8: rewrite during a burst
    mod_en = 1'b0;
    cfg(0, 3, 4);
    mod_en = 1'b1;
    meas(hi, lo, st, ls);
    while (carrier_out == 1'b0) @(negedge clk);
    hi = 1;
    write_reg(1'b1, mod_word(6, 2));
    while (carrier_out == 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (carrier_out == 1'b0) begin lo++; @(negedge clk); end
    check(hi == 3, "R8 old high kept", hi, 3);
    check(lo == 4, "R8 old low kept", lo, 4);
    hi = 0;
    while (carrier_out == 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (carrier_out == 1'b0) begin lo++; @(negedge clk); end
    check(hi == 6, "R8 new high applied", hi, 6);
    check(lo == 2, "R8 new low applied", lo, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule